// File: doc/BRIEF.md
# Keyboard Serial Byte Receiver

This block takes bytes from a keyboard over a two-wire open-collector link, a clock line and a data line that the keyboard drives. Both lines are brought into the system clock domain through flop chains. A falling edge on the synchronized clock line samples one bit. Eleven edges make one frame: a low start bit, eight data bits with the least significant bit first, an odd-parity bit and a high stop bit. A frame that passes every check places its byte in a one-entry host buffer. That sets the buffer-full indication and sends a one-cycle interrupt request to the host.

While the host buffer is occupied, the block asks the board to hold the keyboard clock low, so the keyboard cannot send more. Clock edges that arrive anyway are ignored. A frame with bad parity raises a parity-error flag. A frame whose start or stop bit is wrong is dropped quietly. If a frame stops partway, a gap counter raises a receive-timeout flag and drops the partial frame. Both error flags clear when the next good byte arrives. A translation hook in the package sits between the frame and the buffer. It passes the byte through unchanged.

Top module: `ps2_rx_unit`

## Requirements
- R1: After reset, rx_valid, irq, par_err, rx_tmo and kb_clk_hold are 0 and rx_byte is 8'h00.
- R2: Bits are taken on falling edges of the synchronized keyboard clock. A frame is 11 bits: start (0), data bit 0 through bit 7, parity, stop (1). The accepted data byte appears on rx_byte unaltered.
- R3: Parity is odd: the data bits and the parity bit together must hold an odd number of ones. If the count is even, par_err is set and the byte is not loaded, so rx_valid stays 0.
- R4: A frame whose start bit is 1 or whose stop bit is 0 is dropped. rx_valid stays 0 and neither flag changes.
- R5: Loading a good byte sets rx_valid and pulses irq high for exactly one system clock. rx_byte stays stable while rx_valid is 1.
- R6: A host_rd pulse clears rx_valid. host_rd while the buffer is empty changes nothing. When host_rd falls in the same cycle as a load, the load wins and rx_valid ends at 1.
- R7: kb_clk_hold is 1 exactly while rx_valid is 1. Keyboard clock edges that arrive while the buffer is full are ignored and do not advance the next frame.
- R8: If a frame has started and no falling edge arrives for TMO_CYC system clocks, rx_tmo is set and the partial frame is dropped. The next edge starts a new frame.
- R9: par_err and rx_tmo both clear to 0 when the next good frame is loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| kb_clk_in | input | 1 | Keyboard clock line as received (asynchronous) |
| kb_dat_in | input | 1 | Keyboard data line as received (asynchronous) |
| host_rd | input | 1 | One-cycle pulse: host has taken the buffered byte |
| rx_byte | output | 8 | Buffered byte |
| rx_valid | output | 1 | Host buffer holds an unread byte |
| irq | output | 1 | One-cycle interrupt request on each load |
| par_err | output | 1 | Last completed frame failed the odd-parity check |
| rx_tmo | output | 1 | A frame stalled past the timeout |
| kb_clk_hold | output | 1 | Request to pull the keyboard clock line low |

## Verification
A host read and a buffer load can happen in the same system clock. This occurs when the host empties the buffer just as the stop-bit edge of a new frame leaves the synchronizer. The bench counts the synchronizer and frame registers to find the exact cycle in which the stop bit is judged, and pulses host_rd in that cycle. It then expects rx_valid to remain 1 and rx_byte to show the new byte. A read that wins would lose the byte silently.

// File: rtl/ps2_rx_pkg.sv
`timescale 1ns/1ps
package ps2_rx_pkg;

    localparam int FRAME_BITS = 11;

    typedef logic [7:0] byte_t;

    // Bits in arrival order: start lands at bit 0.
    typedef struct packed {
        logic  stop;
        logic  par;
        byte_t data;
        logic  start;
    } frame_t;

    typedef enum logic [1:0] {
        FR_OK      = 2'd0,
        FR_PARITY  = 2'd1,
        FR_FRAMING = 2'd2
    } verdict_e;

    // Framing is checked before parity.
    function automatic verdict_e judge(input frame_t f);
        if (f.start || !f.stop)
            return FR_FRAMING;
        else if (^{f.data, f.par} == 1'b0)
            return FR_PARITY;
        else
            return FR_OK;
    endfunction

    // Scan-code translation hook: identity.
    function automatic byte_t xlate(input byte_t b);
        return b;
    endfunction

endpackage

// File: rtl/ps2_sync.sv
`timescale 1ns/1ps
module ps2_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic kb_clk_in,
    input  logic kb_dat_in,
    output logic dat_s,
    output logic fall
);
    logic [STAGES-1:0] c_sync;
    logic [STAGES-1:0] d_sync;
    logic              c_prev;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) begin
                    c_sync[0] <= 1'b1;
                    d_sync[0] <= 1'b1;
                end else begin
                    c_sync[0] <= kb_clk_in;
                    d_sync[0] <= kb_dat_in;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) begin
                    c_sync[i] <= 1'b1;
                    d_sync[i] <= 1'b1;
                end else begin
                    c_sync[i] <= c_sync[i-1];
                    d_sync[i] <= d_sync[i-1];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) c_prev <= 1'b1;
        else     c_prev <= c_sync[STAGES-1];
    end

    assign fall  = c_prev & ~c_sync[STAGES-1];
    assign dat_s = d_sync[STAGES-1];

endmodule

// File: rtl/ps2_frame.sv
`timescale 1ns/1ps
module ps2_frame
    import ps2_rx_pkg::*;
#(
    parameter int TMO_CYC = 200000
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   fall,
    input  logic   dat_s,
    input  logic   hold,
    output logic   done,
    output frame_t frm,
    output logic   tmo_hit
);
    localparam int CNT_W = $clog2(FRAME_BITS + 1);
    localparam int SH_W  = FRAME_BITS - 1;
    localparam int GAP_W = $clog2(TMO_CYC + 1);

    logic [CNT_W-1:0] cnt;
    logic [SH_W-1:0]  sh;
    logic [GAP_W-1:0] gap;
    logic             take;
    logic             busy;

    assign take    = fall & ~hold;
    assign busy    = (cnt != '0);
    assign done    = take && (cnt == CNT_W'(FRAME_BITS - 1));
    assign frm     = frame_t'({dat_s, sh});
    assign tmo_hit = busy && !take && (gap == GAP_W'(TMO_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            sh  <= '0;
            gap <= '0;
        end else if (take) begin
            gap <= '0;
            sh  <= {dat_s, sh[SH_W-1:1]};
            cnt <= done ? '0 : cnt + CNT_W'(1);
        end else if (tmo_hit) begin
            cnt <= '0;
            gap <= '0;
        end else if (busy) begin
            gap <= gap + GAP_W'(1);
        end
    end

endmodule

// File: rtl/ps2_obuf.sv
`timescale 1ns/1ps
module ps2_obuf
    import ps2_rx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   done,
    input  frame_t frm,
    input  logic   tmo_hit,
    input  logic   host_rd,
    output byte_t  rx_byte,
    output logic   rx_valid,
    output logic   irq,
    output logic   par_err,
    output logic   rx_tmo
);
    verdict_e verdict;
    logic     load;

    assign verdict = judge(frm);
    assign load    = done && (verdict == FR_OK);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_byte  <= '0;
            rx_valid <= 1'b0;
            irq      <= 1'b0;
            par_err  <= 1'b0;
            rx_tmo   <= 1'b0;
        end else begin
            irq <= load;
            if (load) begin
                rx_byte  <= xlate(frm.data);
                rx_valid <= 1'b1;
                par_err  <= 1'b0;
                rx_tmo   <= 1'b0;
            end else begin
                if (host_rd)
                    rx_valid <= 1'b0;
                if (done && verdict == FR_PARITY)
                    par_err <= 1'b1;
                if (tmo_hit)
                    rx_tmo <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ps2_rx_unit.sv
`timescale 1ns/1ps
module ps2_rx_unit
    import ps2_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int TMO_CYC     = 200000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       kb_clk_in,
    input  logic       kb_dat_in,
    input  logic       host_rd,
    output logic [7:0] rx_byte,
    output logic       rx_valid,
    output logic       irq,
    output logic       par_err,
    output logic       rx_tmo,
    output logic       kb_clk_hold
);
    logic   dat_s;
    logic   fall;
    logic   done;
    logic   tmo_hit;
    frame_t frm;
    logic   full;

    ps2_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .kb_clk_in (kb_clk_in),
        .kb_dat_in (kb_dat_in),
        .dat_s     (dat_s),
        .fall      (fall)
    );

    ps2_frame #(.TMO_CYC(TMO_CYC)) u_frame (
        .clk     (clk),
        .rst     (rst),
        .fall    (fall),
        .dat_s   (dat_s),
        .hold    (full),
        .done    (done),
        .frm     (frm),
        .tmo_hit (tmo_hit)
    );

    ps2_obuf u_obuf (
        .clk      (clk),
        .rst      (rst),
        .done     (done),
        .frm      (frm),
        .tmo_hit  (tmo_hit),
        .host_rd  (host_rd),
        .rx_byte  (rx_byte),
        .rx_valid (full),
        .irq      (irq),
        .par_err  (par_err),
        .rx_tmo   (rx_tmo)
    );

    assign rx_valid    = full;
    assign kb_clk_hold = full;

endmodule

// File: rtl/ps2_rx_chk.sv
`timescale 1ns/1ps
module ps2_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       host_rd,
    input logic [7:0] rx_byte,
    input logic       rx_valid,
    input logic       irq,
    input logic       par_err,
    input logic       rx_tmo,
    input logic       kb_clk_hold
);
    // R5: interrupt request lasts a single cycle
    a_r5_irq_single: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R5: a request comes with a full buffer
    a_r5_irq_full: assert property (@(posedge clk) disable iff (rst)
        irq |-> rx_valid);

    // R5: unread byte does not move
    a_r5_byte_stable: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !host_rd) |=> (rx_valid && $stable(rx_byte)));

    // R6: a read of a full buffer empties it
    a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && host_rd) |=> !rx_valid);

    // R7: inhibit follows buffer occupancy
    a_r7_inhibit: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_valid) |-> kb_clk_hold);

    // R7: inhibit drops once buffer empties
    a_r7_release: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_valid) |-> !kb_clk_hold);

    // R9: a successful load leaves both error flags clear
    a_r9_flags_clear: assert property (@(posedge clk) disable iff (rst)
        irq |-> (!par_err && !rx_tmo));

    // R3: a parity failure never loads
    a_r3_no_load_on_error: assert property (@(posedge clk) disable iff (rst)
        $rose(par_err) |-> !irq);

endmodule

bind ps2_rx_unit ps2_rx_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_rd     (host_rd),
    .rx_byte     (rx_byte),
    .rx_valid    (rx_valid),
    .irq         (irq),
    .par_err     (par_err),
    .rx_tmo      (rx_tmo),
    .kb_clk_hold (kb_clk_hold)
);

// File: tb/tb_ps2_rx_unit.sv
`timescale 1ns/1ps
module tb_ps2_rx_unit;

    localparam int HALF = 20;
    localparam int TMO  = 300;
    localparam int NVEC = 8;

    // {data[7:0], flip parity, bad start, bad stop}
    localparam logic [10:0] VEC [NVEC] = '{
        {8'h1C, 3'b000},
        {8'hF0, 3'b000},
        {8'h00, 3'b000},
        {8'hFF, 3'b100},
        {8'h5A, 3'b000},
        {8'h3C, 3'b010},
        {8'h81, 3'b001},
        {8'hA5, 3'b000}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       kclk = 1'b1;
    logic       kdat = 1'b1;
    logic       host_rd = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_valid, irq, par_err, rx_tmo, kb_clk_hold;

    int checks = 0;
    int failures = 0;
    int irq_cnt = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ps2_rx_unit #(.SYNC_STAGES(2), .TMO_CYC(TMO)) dut (
        .clk         (clk),
        .rst         (rst),
        .kb_clk_in   (kclk),
        .kb_dat_in   (kdat),
        .host_rd     (host_rd),
        .rx_byte     (rx_byte),
        .rx_valid    (rx_valid),
        .irq         (irq),
        .par_err     (par_err),
        .rx_tmo      (rx_tmo),
        .kb_clk_hold (kb_clk_hold)
    );

    always @(negedge clk) if (irq) irq_cnt++;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input bit rd_mid);
        @(negedge clk);
        kdat = b;
        repeat (HALF - 1) @(negedge clk);
        kclk = 1'b0;
        if (rd_mid) begin
            repeat (2) @(negedge clk);
            host_rd = 1'b1;
            @(negedge clk);
            host_rd = 1'b0;
            repeat (HALF - 3) @(negedge clk);
        end else begin
            repeat (HALF) @(negedge clk);
        end
        kclk = 1'b1;
    endtask

    task automatic send_frame(input logic [7:0] d, input bit flip,
                              input bit sbad, input bit tbad, input bit rd_last);
        send_bit(sbad, 1'b0);
        for (int i = 0; i < 8; i++) send_bit(d[i], 1'b0);
        send_bit((~^d) ^ flip, 1'b0);
        send_bit(~tbad, rd_last);
        repeat (10) @(negedge clk);
    endtask

    task automatic host_read();
        @(negedge clk);
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int  irq_before;
        bit  exp_par;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 rx_valid", rx_valid, 0);
        chk("R1 irq", irq, 0);
        chk("R1 par_err", par_err, 0);
        chk("R1 rx_tmo", rx_tmo, 0);
        chk("R1 kb_clk_hold", kb_clk_hold, 0);
        chk("R1 rx_byte", rx_byte, 0);

        // Table walk: R2 R3 R4 R5 R9
        exp_par = 1'b0;
        for (int k = 0; k < NVEC; k++) begin
            logic [7:0] d;
            bit fl, sb, tb, good;
            {d, fl, sb, tb} = VEC[k];
            good = !fl && !sb && !tb;
            irq_before = irq_cnt;
            send_frame(d, fl, sb, tb, 1'b0);
            if (good) begin
                exp_par = 1'b0;
                chk("R2 byte", rx_byte, d);
                chk("R5 rx_valid", rx_valid, 1);
                chk("R5 irq once", irq_cnt - irq_before, 1);
                chk("R7 hold while full", kb_clk_hold, 1);
                chk("R9 par_err cleared", par_err, 0);
                host_read();
                chk("R6 read clears", rx_valid, 0);
                chk("R7 hold released", kb_clk_hold, 0);
            end else begin
                if (!sb && !tb) exp_par = 1'b1;
                chk(sb || tb ? "R4 no load" : "R3 no load", rx_valid, 0);
                chk(sb || tb ? "R4 no irq" : "R3 no irq", irq_cnt - irq_before, 0);
                chk(sb || tb ? "R4 par_err kept" : "R3 par_err set", par_err, exp_par);
            end
        end

        // R6 read while empty: no effect
        host_read();
        chk("R6 empty read valid", rx_valid, 0);
        chk("R6 empty read byte", rx_byte, 8'hA5);

        // R6 read in the load cycle: load wins
        send_frame(8'h3A, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R6 same-cycle valid", rx_valid, 1);
        chk("R6 same-cycle byte", rx_byte, 8'h3A);
        host_read();

        // R7 edges while full are ignored
        irq_before = irq_cnt;
        send_frame(8'h11, 1'b0, 1'b0, 1'b0, 1'b0);
        send_frame(8'h22, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R7 byte kept", rx_byte, 8'h11);
        chk("R7 still full", rx_valid, 1);
        chk("R7 single irq", irq_cnt - irq_before, 1);
        host_read();
        repeat (20) @(negedge clk);
        chk("R7 no late load", rx_valid, 0);
        send_frame(8'h33, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R7 fresh frame after read", rx_byte, 8'h33);
        host_read();

        // R8 stalled frame
        send_bit(1'b0, 1'b0);
        send_bit(1'b1, 1'b0);
        send_bit(1'b1, 1'b0);
        repeat (TMO / 2) @(negedge clk);
        chk("R8 not yet", rx_tmo, 0);
        repeat (TMO) @(negedge clk);
        chk("R8 timeout set", rx_tmo, 1);
        chk("R8 no load", rx_valid, 0);
        send_frame(8'h77, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R8 restart byte", rx_byte, 8'h77);
        chk("R9 rx_tmo cleared", rx_tmo, 0);
        host_read();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule